// File: doc/BRIEF.md
# Parallel EEPROM Write Capture

This block is the device side of an asynchronous parallel EEPROM write port, observed by a fast system clock. Three active-low strobes (chip select, write enable, output enable) and the address and data buses come in without any clock relation. They pass through a synchroniser. The block then finds the strobe edges that bound a write. It takes the address when the second of the two write strobes falls, and it takes the data when the first of them rises. Each captured pair goes into a small page buffer.

Every falling write-enable edge opens a page window, or restarts it from zero if one is already open. When the window runs out with data in the buffer, the block asserts busy for a fixed programming interval. While busy is high, the buffered pairs are sent out one per cycle on a commit interface, in capture order. Write attempts made while busy are dropped and reported. The window length and the programming interval are given in microseconds and converted into system-clock cycles from a clock-frequency parameter.

Top module: `ewc_write_capture`

## Requirements
- R1: During reset and in the first cycle after it, `busy`, `reject` and `cmt_valid` are all 0.
- R2: A write is accepted only if `out_en_n` is 1 when both `chip_sel_n` and `wr_en_n` are 0. A strobe pair that goes low while `out_en_n` is 0 adds nothing to the buffer.
- R3: The stored address is the `addr_in` value present when the second of `chip_sel_n` and `wr_en_n` goes low. This holds whichever strobe falls last.
- R4: The stored data is the `data_in` value present when the first of `chip_sel_n` and `wr_en_n` goes high. Changes to the bus after that point are not stored.
- R5: Each falling edge of `wr_en_n` while not busy starts the page window. A falling edge inside an open window restarts it from zero. If the window closes with data buffered, `busy` rises PAGE_CYC+3 clock edges after the last such falling edge was driven. PAGE_CYC = CLK_KHZ*PAGE_US/1000.
- R6: `busy` stays high for exactly PROG_CYC cycles (CLK_KHZ*PROG_US/1000). Starting the cycle after `busy` rises, the buffered pairs appear on `cmt_valid`/`cmt_addr`/`cmt_data` on consecutive cycles, oldest first. `cmt_last` marks the final pair.
- R7: If a window closes with an empty buffer, `busy` does not rise.
- R8: A write attempted while busy stores nothing. It gives one single-cycle `reject` pulse, and its write-enable edge does not open a new window.
- R9: A write that completes while the buffer already holds BUF_DEPTH pairs is discarded, and `reject` pulses for one cycle.
- R10: The window does not close while a write is in progress (both strobes still low). It closes once the strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Asynchronous chip select, active low |
| wr_en_n | input | 1 | Asynchronous write enable, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low; must be high for a write |
| addr_in | input | ADDR_W | Address bus |
| data_in | input | DATA_W | Data bus |
| busy | output | 1 | Programming interval in progress |
| reject | output | 1 | One-cycle pulse for a dropped write |
| cmt_valid | output | 1 | Commit entry valid |
| cmt_addr | output | ADDR_W | Committed address |
| cmt_data | output | DATA_W | Committed data |
| cmt_last | output | 1 | Final entry of the page |

## Verification
Three clock edges after a strobe change is driven, that change reaches the capture registers. So a dropped write shows up on `reject` three edges after its strobe. The window closes PAGE_CYC+3 edges after the falling write-enable edge that last started it. The first commit entry arrives one edge after `busy` rises, and `busy` falls PROG_CYC edges after it rose. The bench drives inputs just after the falling clock edge. A behavioural model steps on every rising edge, and every output is compared with that model at the next falling edge, so each result is checked exactly in the cycle it is due. Explicit checks then measure the window-to-busy delay, the busy length and the committed contents against hand-computed values.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  typedef enum logic [1:0] {
    TMR_IDLE,
    TMR_WINDOW,
    TMR_PROG
  } tmr_state_e;

  // Cycles of a clock of clk_khz in usec microseconds.
  function automatic int unsigned cycles_for(int unsigned clk_khz, int unsigned usec);
    longint unsigned prod;
    prod = (longint'(clk_khz) * longint'(usec)) / 1000;
    return prod[31:0];
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ewc_strobe_decode.sv
module ewc_strobe_decode #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              we_s,
  input  logic              oe_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  input  logic              busy,
  input  logic              full,
  output logic              we_fall,
  output logic              hold,
  output logic              push,
  output logic [ADDR_W-1:0] push_addr,
  output logic [DATA_W-1:0] push_data,
  output logic              reject
);

  logic              cs_p, we_p;
  logic              in_wr;
  logic [ADDR_W-1:0] addr_lat;
  logic              both_low, both_low_p;
  logic              wr_start, wr_end;

  // Both strobes low forms the write window; its rise is the later fall,
  // its fall is the earlier rise.
  always_comb begin
    both_low   = ~cs_s & ~we_s;
    both_low_p = ~cs_p & ~we_p;
    wr_start   = both_low & ~both_low_p & oe_s;
    wr_end     = ~both_low & both_low_p & in_wr;
    we_fall    = ~we_s & we_p;
  end

  assign hold      = in_wr | wr_start;
  assign push      = wr_end & ~full;
  assign push_addr = addr_lat;
  assign push_data = data_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p     <= 1'b1;
      we_p     <= 1'b1;
      in_wr    <= 1'b0;
      addr_lat <= '0;
      reject   <= 1'b0;
    end else begin
      cs_p   <= cs_s;
      we_p   <= we_s;
      reject <= (wr_start & busy) | (wr_end & full);
      if (wr_start && !busy) begin
        in_wr    <= 1'b1;
        addr_lat <= addr_s;
      end else if (wr_end) begin
        in_wr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ewc_page_timer.sv
module ewc_page_timer
  import ewc_pkg::*;
#(
  parameter int unsigned PAGE_CYC = 37500,
  parameter int unsigned PROG_CYC = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic we_fall,
  input  logic hold,
  input  logic buf_nonempty,
  output logic busy,
  output logic commit_go
);

  localparam int unsigned CNT_MAX = max_u(PAGE_CYC, PROG_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  tmr_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TMR_IDLE;
      cnt       <= '0;
      commit_go <= 1'b0;
    end else begin
      commit_go <= 1'b0;
      unique case (state)
        TMR_IDLE: begin
          if (we_fall) begin
            state <= TMR_WINDOW;
            cnt   <= CNT_W'(PAGE_CYC - 1);
          end
        end
        TMR_WINDOW: begin
          if (we_fall) begin
            cnt <= CNT_W'(PAGE_CYC - 1);
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!hold) begin
            if (buf_nonempty) begin
              state     <= TMR_PROG;
              cnt       <= CNT_W'(PROG_CYC - 1);
              commit_go <= 1'b1;
            end else begin
              state <= TMR_IDLE;
            end
          end
        end
        TMR_PROG: begin
          if (cnt == '0) state <= TMR_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= TMR_IDLE;
      endcase
    end
  end

  assign busy = (state == TMR_PROG);

endmodule

// File: rtl/ewc_page_buf.sv
module ewc_page_buf #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              commit_go,
  output logic              full,
  output logic              nonempty,
  output logic              cmt_valid,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data,
  output logic              cmt_last
);

  localparam int unsigned ENTRY_W = ADDR_W + DATA_W;
  localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [ENTRY_W-1:0] rd_word;
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count;
  logic               draining;
  logic               pop;

  assign full     = (count == CNT_W'(DEPTH));
  assign nonempty = (count != '0);
  assign pop      = (commit_go | draining) & nonempty;

  // Storage without reset, written and read on registered ports.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (pop) rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      draining  <= 1'b0;
      cmt_valid <= 1'b0;
      cmt_last  <= 1'b0;
    end else begin
      cmt_valid <= pop;
      cmt_last  <= pop && (count == CNT_W'(1));
      draining  <= pop && (count != CNT_W'(1));
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign cmt_addr = rd_word[ENTRY_W-1:DATA_W];
  assign cmt_data = rd_word[DATA_W-1:0];

endmodule

// File: rtl/ewc_write_capture.sv
module ewc_write_capture #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BUF_DEPTH   = 8,
  parameter int unsigned CLK_KHZ     = 250000,
  parameter int unsigned PAGE_US     = 150,
  parameter int unsigned PROG_US     = 6000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              reject,
  output logic              cmt_valid,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data,
  output logic              cmt_last
);

  localparam int unsigned PAGE_CYC = ewc_pkg::cycles_for(CLK_KHZ, PAGE_US);
  localparam int unsigned PROG_CYC = ewc_pkg::cycles_for(CLK_KHZ, PROG_US);
  localparam int unsigned BUS_W    = ADDR_W + DATA_W;

  logic [2:0]        strobe_s;
  logic [BUS_W-1:0]  bus_s;
  logic              we_fall, hold, push, full, nonempty, commit_go;
  logic [ADDR_W-1:0] push_addr;
  logic [DATA_W-1:0] push_data;

  // Strobes and buses go through the same depth so they stay aligned.
  ewc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strobe (
    .clk (clk),
    .rst (rst),
    .d   ({chip_sel_n, wr_en_n, out_en_n}),
    .q   (strobe_s)
  );

  ewc_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk (clk),
    .rst (rst),
    .d   ({addr_in, data_in}),
    .q   (bus_s)
  );

  ewc_strobe_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (strobe_s[2]),
    .we_s      (strobe_s[1]),
    .oe_s      (strobe_s[0]),
    .addr_s    (bus_s[BUS_W-1:DATA_W]),
    .data_s    (bus_s[DATA_W-1:0]),
    .busy      (busy),
    .full      (full),
    .we_fall   (we_fall),
    .hold      (hold),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .reject    (reject)
  );

  ewc_page_timer #(.PAGE_CYC(PAGE_CYC), .PROG_CYC(PROG_CYC)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .we_fall      (we_fall),
    .hold         (hold),
    .buf_nonempty (nonempty),
    .busy         (busy),
    .commit_go    (commit_go)
  );

  ewc_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .commit_go (commit_go),
    .full      (full),
    .nonempty  (nonempty),
    .cmt_valid (cmt_valid),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data),
    .cmt_last  (cmt_last)
  );

endmodule

// File: rtl/ewc_write_capture_chk.sv
module ewc_write_capture_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic reject,
  input logic cmt_valid,
  input logic cmt_last
);

  AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmt_valid |-> busy); // R6

  AST_COMMIT_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> cmt_valid); // R6

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R6

  AST_DRAIN_CONTIGUOUS: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && !cmt_last) |=> cmt_valid); // R6

  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid && cmt_last) |=> !cmt_valid); // R6

  AST_REJECT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reject |=> !reject); // R8

endmodule

bind ewc_write_capture ewc_write_capture_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .reject    (reject),
  .cmt_valid (cmt_valid),
  .cmt_last  (cmt_last)
);

// File: tb/sim_ewc_write_capture.sv
`timescale 1ns/1ps
module sim_ewc_write_capture;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 4;
  localparam int KHZ = 1000;
  localparam int PAGE_US = 150;
  localparam int PROG_US = 400;
  localparam int P = KHZ * PAGE_US / 1000;
  localparam int G = KHZ * PROG_US / 1000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic chip_sel_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic busy, reject, cmt_valid, cmt_last;
  logic [AW-1:0] cmt_addr;
  logic [DW-1:0] cmt_data;

  ewc_write_capture #(
    .ADDR_W(AW), .DATA_W(DW), .BUF_DEPTH(DEPTH), .CLK_KHZ(KHZ),
    .PAGE_US(PAGE_US), .PROG_US(PROG_US), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_en_n(wr_en_n),
    .out_en_n(out_en_n), .addr_in(addr_in), .data_in(data_in),
    .busy(busy), .reject(reject), .cmt_valid(cmt_valid),
    .cmt_addr(cmt_addr), .cmt_data(cmt_data), .cmt_last(cmt_last)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_cs1, m_cs2, m_csp, m_we1, m_we2, m_wep, m_oe1, m_oe2;
  bit [AW-1:0] m_a1, m_a2, m_alat;
  bit [DW-1:0] m_d1, m_d2;
  bit m_inwr, m_go, m_drain, m_cv, m_cl, m_rej;
  bit [AW-1:0] m_ca;
  bit [DW-1:0] m_cd;
  bit [AW+DW-1:0] m_q[$];
  int m_state, m_cnt;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      {m_cs1, m_cs2, m_csp, m_we1, m_we2, m_wep, m_oe1, m_oe2} = '1;
      m_a1 = 0; m_a2 = 0; m_d1 = 0; m_d2 = 0; m_alat = 0;
      m_inwr = 0; m_go = 0; m_drain = 0; m_cv = 0; m_cl = 0; m_rej = 0;
      m_q.delete(); m_state = 0; m_cnt = 0;
    end else begin
      bit act, actp, st, fl, en, bsy, full, nonempty, hold, old_go;
      bit [AW+DW-1:0] e;
      act = !m_cs2 && !m_we2;
      actp = !m_csp && !m_wep;
      st = act && !actp && m_oe2;
      fl = !m_we2 && m_wep;
      en = !act && actp && m_inwr;
      bsy = (m_state == 2);
      full = (m_q.size() == DEPTH);
      nonempty = (m_q.size() != 0);
      hold = m_inwr || st;
      old_go = m_go;
      if ((old_go || m_drain) && nonempty) begin
        e = m_q.pop_front();
        m_cv = 1; m_ca = e[AW+DW-1:DW]; m_cd = e[DW-1:0];
        m_cl = (m_q.size() == 0); m_drain = (m_q.size() != 0);
      end else begin
        m_cv = 0; m_cl = 0; m_drain = 0;
      end
      m_rej = (st && bsy) || (en && full);
      if (en && !full) m_q.push_back({m_alat, m_d2});
      if (st && !bsy) begin m_inwr = 1; m_alat = m_a2; end
      else if (en) m_inwr = 0;
      m_go = 0;
      case (m_state)
        0: if (fl) begin m_state = 1; m_cnt = P - 1; end
        1: begin
          if (fl) m_cnt = P - 1;
          else if (m_cnt != 0) m_cnt--;
          else if (!hold) begin
            if (nonempty) begin m_state = 2; m_cnt = G - 1; m_go = 1; end
            else m_state = 0;
          end
        end
        default: if (m_cnt == 0) m_state = 0; else m_cnt--;
      endcase
      m_csp = m_cs2; m_cs2 = m_cs1; m_cs1 = chip_sel_n;
      m_wep = m_we2; m_we2 = m_we1; m_we1 = wr_en_n;
      m_oe2 = m_oe1; m_oe1 = out_en_n;
      m_a2 = m_a1; m_a1 = addr_in;
      m_d2 = m_d1; m_d1 = data_in;
    end
  end

  // ---------------- monitor: per-cycle compare and logging ----------------
  bit [AW+DW-1:0] got[$];
  int rej_cnt = 0, busy_rises = 0, busy_len = 0, t_busy = 0, t_fall = 0;
  bit busy_d = 0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5", "busy vs model", int'(busy), int'(m_state == 2));
      chk("R8", "reject vs model", int'(reject), int'(m_rej));
      chk("R6", "cmt_valid vs model", int'(cmt_valid), int'(m_cv));
      if (m_cv) begin
        chk("R3", "cmt_addr vs model", int'(cmt_addr), int'(m_ca));
        chk("R4", "cmt_data vs model", int'(cmt_data), int'(m_cd));
        chk("R6", "cmt_last vs model", int'(cmt_last), int'(m_cl));
      end
      if (cmt_valid) got.push_back({cmt_addr, cmt_data});
      if (reject) rej_cnt++;
      if (busy && !busy_d) begin busy_rises++; t_busy = cyc; busy_len = 0; end
      if (busy) busy_len++;
      busy_d = busy;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Write controlled by the write-enable strobe; chip select falls first.
  task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
    chip_sel_n = 0; addr_in = ~a; idle(3);
    addr_in = a; wr_en_n = 0; t_fall = cyc; idle(2);
    data_in = d; idle(3);
    wr_en_n = 1; idle(1);
    data_in = ~d; addr_in = ~a; idle(3);
    chip_sel_n = 1; idle(3);
  endtask

  // Write controlled by chip select; write enable falls first.
  task automatic wr_cs(input logic [AW-1:0] a0, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    addr_in = a0; wr_en_n = 0; t_fall = cyc; idle(3);
    addr_in = a; chip_sel_n = 0; idle(4);
    data_in = d; idle(3);
    chip_sel_n = 1; idle(1);
    data_in = ~d; idle(3);
    wr_en_n = 1; idle(3);
  endtask

  task automatic chk_entry(string req, int idx, logic [AW-1:0] a, logic [DW-1:0] d);
    if (idx < got.size()) begin
      chk(req, "committed addr", int'(got[idx][AW+DW-1:DW]), int'(a));
      chk(req, "committed data", int'(got[idx][DW-1:0]), int'(d));
    end else begin
      chk(req, "committed entry present", 0, 1);
    end
  endtask

  initial begin
    int r0, b0;
    idle(2);
    // R1: reset values while reset is held
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "reject in reset", int'(reject), 0);
    chk("R1", "cmt_valid in reset", int'(cmt_valid), 0);
    idle(2);
    rst = 0;
    idle(1);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "cmt_valid after reset", int'(cmt_valid), 0);

    // R3 R4 R5 R6: two WE-controlled writes in one page
    got.delete();
    wr_we(8'h11, 8'hA1);
    wr_we(8'h22, 8'hB2);
    idle(P + 10);
    chk("R5", "window to busy delay", t_busy - t_fall, P + 3);
    idle(G + 10);
    chk("R6", "busy length", busy_len, G);
    chk("R6", "commit count", got.size(), 2);
    chk_entry("R3", 0, 8'h11, 8'hA1);
    chk_entry("R4", 1, 8'h22, 8'hB2);

    // R3 R4: chip-select controlled write, address moves before the later fall
    got.delete();
    wr_cs(8'h05, 8'h33, 8'hC3);
    idle(P + G + 40);
    chk("R3", "cs-controlled commit count", got.size(), 1);
    chk_entry("R3", 0, 8'h33, 8'hC3);

    // R2 R7: output enable low, nothing stored, window closes empty
    got.delete();
    b0 = busy_rises;
    out_en_n = 0;
    wr_we(8'h44, 8'hD4);
    out_en_n = 1;
    idle(P + 40);
    chk("R2", "no commit with output enable low", got.size(), 0);
    chk("R7", "no busy on empty window", busy_rises, b0);

    // R5: retriggered window keeps three spaced writes in one page
    got.delete();
    b0 = busy_rises;
    wr_we(8'h01, 8'h10);
    idle(100);
    wr_we(8'h02, 8'h20);
    idle(100);
    wr_we(8'h03, 8'h30);
    idle(P + 10);
    chk("R5", "single busy for retriggered page", busy_rises, b0 + 1);
    chk("R5", "retriggered delay", t_busy - t_fall, P + 3);
    idle(G + 20);
    chk("R5", "retriggered commit count", got.size(), 3);
    chk_entry("R6", 2, 8'h03, 8'h30);

    // R8: write during busy is rejected and opens no window
    got.delete();
    b0 = busy_rises;
    wr_we(8'h55, 8'h5A);
    idle(P + 10);
    chk("R8", "busy before attempt", int'(busy), 1);
    r0 = rej_cnt;
    wr_we(8'h66, 8'h6A);
    idle(2);
    chk("R8", "reject pulses", rej_cnt, r0 + 1);
    idle(G + P + 20);
    chk("R8", "busy rises once", busy_rises, b0 + 1);
    chk("R8", "only accepted write committed", got.size(), 1);
    chk_entry("R8", 0, 8'h55, 8'h5A);

    // R9: one write beyond buffer depth is dropped
    got.delete();
    r0 = rej_cnt;
    for (int i = 0; i < DEPTH + 1; i++) wr_we(8'h80 + 8'(i), 8'hF0 + 8'(i));
    idle(P + G + 40);
    chk("R9", "overflow reject", rej_cnt, r0 + 1);
    chk("R9", "commit count at depth", got.size(), DEPTH);
    chk_entry("R9", DEPTH - 1, 8'h80 + 8'(DEPTH - 1), 8'hF0 + 8'(DEPTH - 1));

    // R10: held write keeps the window open
    got.delete();
    chip_sel_n = 0; addr_in = 8'h77; wr_en_n = 0; t_fall = cyc; data_in = 8'hE7;
    idle(P + 30);
    chk("R10", "busy while write held", int'(busy), 0);
    wr_en_n = 1; idle(2);
    chip_sel_n = 1; idle(10);
    chk("R10", "busy after release", int'(busy), 1);
    idle(G + 20);
    chk("R10", "held write committed", got.size(), 1);
    chk_entry("R10", 0, 8'h77, 8'hE7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule